// File: doc/BRIEF.md
# Repeating-Bitmask Immediate Encoder

This block decides whether a 32- or 64-bit constant can be written as one contiguous run of ones, rotated inside an element of 2, 4, 8, 16, 32 or 64 bits, with that element repeated across the whole register. When the constant has this form, the block returns the 13-bit field triple `{N, immr, imms}` that an instruction encoder places in a logical-immediate slot. When it does not, the block reports the constant as unencodable.

A request is a one-cycle `start_i` pulse, with the constant on `value_i` and the width on `wide_i` (1 means 64-bit, 0 means 32-bit). The controller first screens out trivially bad inputs. It then steps through candidate element sizes one per clock, from half the register width downward, and measures the ones run in the chosen element. Finally it registers the result with a one-cycle `done_o` pulse. The controller has four states:

- `ST_IDLE` waits for `start_i`. On a start it takes the screen-reject transition to `ST_RESULT`, or the accept transition to `ST_SCAN`.
- `ST_SCAN` probes one size per cycle. It takes the stop transition to `ST_MEASURE` when a size fails to repeat, or after size 2 has repeated. Otherwise it takes the halve transition back to itself.
- `ST_MEASURE` evaluates the run and always moves to `ST_RESULT`.
- `ST_RESULT` is the `done_o` cycle and always returns to `ST_IDLE`.

Top module: `lmask_encoder`

## Requirements
- R1: A zero constant is rejected. `done_o` is high in the cycle after the clock edge that samples `start_i`, with `valid_o`=0 and `code_o`=0.
- R2: In 32-bit mode (`wide_i`=0), a constant with any of bits 63:32 set is rejected with the same timing and outputs as R1.
- R3: The element size e is the smallest power of two from 2 to W (W = 64 or 32) for which bit i equals bit (i+e) mod W for every i below W.
- R4: The e-bit element must contain exactly one cyclic run of ones. Any other pattern, including all ones, gives `valid_o`=0 and `code_o`=0.
- R5: `code_o` carries imms in bits 5:0, immr in bits 11:6 and N in bit 12. N is 1 only when e is 64.
- R6: immr equals (e − r) mod e. Here r is the right rotation that moves the run so it starts at bit 0 of the element.
- R7: imms equals the count of ones minus 1, ORed with a size prefix: 0x20 for e=16, 0x30 for e=8, 0x38 for e=4, 0x3C for e=2, and none for e=32 or 64.
- R8: For an accepted request, sizes W/2, W/4, … are probed one per cycle. Probing stops after the first size that does not repeat, or after size 2. If k sizes were probed, `done_o` goes high k+2 cycles after the sampling edge of `start_i`. `done_o` stays high for exactly one cycle.
- R9: `start_i` is ignored from the cycle after a request is accepted up to and including its `done_o` cycle.
- R10: Reset clears `done_o`, `valid_o` and `code_o`. `valid_o` and `code_o` change only together with a `done_o` pulse and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled in idle |
| wide_i | input | 1 | 1 = 64-bit register, 0 = 32-bit register |
| value_i | input | 64 | Constant to encode |
| done_o | output | 1 | One-cycle result strobe |
| valid_o | output | 1 | Constant is encodable |
| code_o | output | 13 | Packed {N, immr, imms} |

## Verification
The bench uses hand-picked constants, one for each element size. Alternating bit pairs and nibble patterns select sizes 2 and 4. Patterns like 0x00FF… select 16. A run that wraps across bit 31 checks the cyclic rotation, and single high or low bits check e=64 and immr wrap. These cases separate the size prefix, the rotation and the N bit. Zero, all ones, two-run elements and 32-bit constants with stray upper bits each exercise a different rejection path. Random rotated runs, some with one flipped bit, vary the scan depth, so the latency rule is checked at each stopping point. A second start pulse issued mid-request shows that busy-time strobes do not disturb the result.

// File: rtl/lmask_pkg.sv
package lmask_pkg;

    localparam int unsigned MAX_W  = 64;
    localparam int unsigned FLD_W  = $clog2(MAX_W);
    localparam int unsigned CODE_W = 2 * FLD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MEASURE,
        ST_RESULT
    } lm_state_e;

    typedef struct packed {
        logic             n;
        logic [FLD_W-1:0] immr;
        logic [FLD_W-1:0] imms;
    } lm_code_t;

endpackage

// File: rtl/lmask_repl_check.sv
module lmask_repl_check #(
    parameter int W   = 64,
    parameter int LGW = 3
) (
    input  logic [W-1:0]   word_i,
    input  logic           wide_i,
    input  logic [LGW-1:0] lg_i,
    output logic           rep_o
);
    localparam int LGM  = $clog2(W);
    localparam int NSEL = 1 << LGW;
    localparam int H    = W / 2;

    logic [NSEL-1:0] rep_full;
    logic [NSEL-1:0] rep_half;

    // one periodicity comparator per candidate size, for both register widths
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_size
            localparam int S = (g >= 1 && g <= LGM) ? (1 << g) : 1;
            if (g == 0 || g > LGM) begin : g_none
                assign rep_full[g] = 1'b0;
                assign rep_half[g] = 1'b0;
            end else begin : g_real
                if (g == LGM) begin : g_full_top
                    assign rep_full[g] = 1'b1;
                end else begin : g_full_cmp
                    assign rep_full[g] = (word_i == {word_i[W-S-1:0], word_i[W-1:W-S]});
                end
                if (g >= LGM - 1) begin : g_half_top
                    assign rep_half[g] = 1'b1;
                end else begin : g_half_cmp
                    assign rep_half[g] = (word_i[H-1:0] == {word_i[H-S-1:0], word_i[H-1:H-S]});
                end
            end
        end
    endgenerate

    assign rep_o = wide_i ? rep_full[lg_i] : rep_half[lg_i];

endmodule

// File: rtl/lmask_run_analyzer.sv
module lmask_run_analyzer #(
    parameter int W   = 64,
    parameter int LGW = 3
) (
    input  logic [W-1:0]         word_i,
    input  logic                 wide_i,
    input  logic [LGW-1:0]       lg_i,
    output logic                 single_o,
    output logic [$clog2(W):0]   ones_o,
    output logic [$clog2(W)-1:0] start_o
);
    localparam int LGM = $clog2(W);
    localparam int H   = W / 2;

    logic [W-1:0] elem_mask;
    logic [W-1:0] rise;
    logic [W-1:0] rise_in;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            elem_mask[i] = (i < (1 << lg_i));
        end
    end

    // a rising edge marks the first bit of a run; the word is periodic in
    // the element size, so the neighbour of bit 0 is the register top bit
    generate
        for (genvar i = 0; i < W; i++) begin : g_rise
            if (i == 0) begin : g_wrap
                assign rise[i] = word_i[0] & ~(wide_i ? word_i[W-1] : word_i[H-1]);
            end else begin : g_lin
                assign rise[i] = word_i[i] & ~word_i[i-1];
            end
        end
    endgenerate

    assign rise_in  = rise & elem_mask;
    assign single_o = ($countones(rise_in) == 1);

    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + {{LGM{1'b0}}, word_i[i] & elem_mask[i]};
        end
    end

    always_comb begin
        start_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (rise_in[i]) begin
                start_o = LGM'(i);
            end
        end
    end

endmodule

// File: rtl/lmask_encoder.sv
module lmask_encoder
    import lmask_pkg::*;
#(
    parameter int W = lmask_pkg::MAX_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic                   wide_i,
    input  logic [W-1:0]           value_i,
    output logic                   done_o,
    output logic                   valid_o,
    output logic [2*$clog2(W):0]   code_o
);
    localparam int LGM = $clog2(W);
    localparam int LGW = $clog2(LGM + 1);
    localparam int FW  = LGM;
    localparam int H   = W / 2;

    lm_state_e      state_q, state_d;
    logic [W-1:0]   val_q;
    logic           wide_q;
    logic [LGW-1:0] probe_q;
    logic [LGW-1:0] best_q;
    logic           busy;

    logic           screen_rej;
    logic           rep;
    logic           single;
    logic [LGM:0]   ones;
    logic [LGM-1:0] run_start;
    logic [LGM:0]   elem_size;
    logic [LGM:0]   immr_full;
    logic [FW-1:0]  imms_prefix;
    logic [FW-1:0]  imms_val;
    lm_code_t       code_new;

    assign busy       = (state_q != ST_IDLE);
    assign screen_rej = (value_i == '0) || (!wide_i && (value_i[W-1:H] != '0));

    lmask_repl_check #(.W(W), .LGW(LGW)) u_repl (
        .word_i (val_q),
        .wide_i (wide_q),
        .lg_i   (probe_q),
        .rep_o  (rep)
    );

    lmask_run_analyzer #(.W(W), .LGW(LGW)) u_run (
        .word_i   (val_q),
        .wide_i   (wide_q),
        .lg_i     (best_q),
        .single_o (single),
        .ones_o   (ones),
        .start_o  (run_start)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = screen_rej ? ST_RESULT : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!rep || probe_q == LGW'(1)) begin
                    state_d = ST_MEASURE;
                end
            end
            ST_MEASURE: state_d = ST_RESULT;
            ST_RESULT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and scan datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            val_q   <= '0;
            wide_q  <= 1'b0;
            probe_q <= '0;
            best_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                val_q   <= value_i;
                wide_q  <= wide_i;
                best_q  <= wide_i ? LGW'(LGM) : LGW'(LGM - 1);
                probe_q <= wide_i ? LGW'(LGM - 1) : LGW'(LGM - 2);
            end else if (state_q == ST_SCAN && rep) begin
                best_q  <= probe_q;
                probe_q <= probe_q - LGW'(1);
            end
        end
    end

    // field assembly from the measured run
    always_comb begin
        elem_size   = (LGM + 1)'(1) << best_q;
        immr_full   = (elem_size - {1'b0, run_start}) & (elem_size - (LGM + 1)'(1));
        imms_prefix = {FW{1'b1}} << ({1'b0, best_q} + (LGW + 1)'(1));
        imms_val    = FW'(ones - (LGM + 1)'(1)) | imms_prefix;
        code_new.n    = (best_q == LGW'(LGM));
        code_new.immr = immr_full[FW-1:0];
        code_new.imms = imms_val;
    end

    // registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_IDLE && start_i && screen_rej) begin
                done_o  <= 1'b1;
                valid_o <= 1'b0;
                code_o  <= '0;
            end else if (state_q == ST_MEASURE) begin
                done_o  <= 1'b1;
                valid_o <= single;
                code_o  <= single ? code_new : '0;
            end
        end
    end

endmodule

// File: rtl/lmask_encoder_checker.sv
module lmask_encoder_checker #(
    parameter int W = 64
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 start_i,
    input logic                 wide_i,
    input logic [W-1:0]         value_i,
    input logic                 busy_i,
    input logic                 done_o,
    input logic                 valid_o,
    input logic [2*$clog2(W):0] code_o
);
    localparam int FW = $clog2(W);

    logic wide_seen;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wide_seen <= 1'b0;
        end else if (start_i && !busy_i) begin
            wide_seen <= wide_i;
        end
    end

    a_r1_zero_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && value_i == '0) |=> (done_o && !valid_o && code_o == '0));

    a_r2_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && !wide_i && value_i[W-1:W/2] != '0) |=> (done_o && !valid_o));

    a_r4_reject_clears_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !valid_o) |-> (code_o == '0));

    a_r5_n_only_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && valid_o && code_o[2*FW]) |-> wide_seen);

    a_r7_imms_never_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && valid_o) |-> (code_o[FW-1:0] != {FW{1'b1}}));

    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r9_done_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> ($past(busy_i) || $past(start_i)));

    a_r10_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(code_o) && $stable(valid_o)));

endmodule

bind lmask_encoder lmask_encoder_checker #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .wide_i  (wide_i),
    .value_i (value_i),
    .busy_i  (busy),
    .done_o  (done_o),
    .valid_o (valid_o),
    .code_o  (code_o)
);

// File: tb/lmask_encoder_tb.sv
`timescale 1ns/1ps
module lmask_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b1;
    logic [63:0] value = '0;
    logic        done;
    logic        valid;
    logic [12:0] code;

    int n_vec  = 0;
    int n_bad  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lmask_encoder u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .wide_i  (wide),
        .value_i (value),
        .done_o  (done),
        .valid_o (valid),
        .code_o  (code)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit periodic(input logic [63:0] v, input int w, input int s);
        for (int i = 0; i < w; i++) begin
            if (v[i] != v[(i + s) % w]) return 0;
        end
        return 1;
    endfunction

    // behavioural reference for R1..R8
    function automatic void model(input logic [63:0] v, input bit wd, output bit ok,
                                  output logic [12:0] cd, output int lat);
        int w, e, s, k, runs, first, ones, immr, imms;
        ok = 0; cd = '0;
        w = wd ? 64 : 32;
        if (v == 0 || (!wd && v[63:32] != 0)) begin
            lat = 1;
            return;
        end
        e = w; s = w / 2; k = 0;
        while (1) begin
            k++;
            if (periodic(v, w, s)) begin
                e = s;
                if (s == 2) break;
                s = s / 2;
            end else break;
        end
        lat = k + 2;
        runs = 0; first = 0; ones = 0;
        for (int i = 0; i < e; i++) begin
            if (v[i]) ones++;
            if (v[i] && !v[(i + e - 1) % e]) begin
                runs++;
                first = i;
            end
        end
        if (runs != 1) return;
        ok = 1;
        immr = (e - first) % e;
        imms = ones - 1;
        case (e)
            16: imms = imms | 32'h20;
            8:  imms = imms | 32'h30;
            4:  imms = imms | 32'h38;
            2:  imms = imms | 32'h3C;
            default: ;
        endcase
        cd = {(e == 64), 6'(immr), 6'(imms)};
    endfunction

    task automatic run(input logic [63:0] v, input bit wd, input bit poke, input string req);
        bit          eok;
        logic [12:0] ecd;
        int          lat;
        logic [12:0] held;
        model(v, wd, eok, ecd, lat);
        @(negedge clk);
        start = 1'b1; value = v; wide = wd;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= lat + 1; c++) begin
            if (c > 1) @(negedge clk);
            if (poke && c == 1) begin
                start = 1'b1; value = ~v; wide = ~wd;
            end else if (poke && c == 2) begin
                start = 1'b0;
            end
            if (c <= lat) check(done == (c == lat), "R8 done timing", 64'(done), 64'(c == lat));
            if (c == lat) begin
                check(valid == eok, {req, " valid"}, 64'(valid), 64'(eok));
                check(code == ecd, {req, " code"}, 64'(code), 64'(ecd));
                held = code;
            end
            if (c == lat + 1) begin
                check(!done && code == held, "R10 hold after done", 64'(code), 64'(held));
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !valid && code == 0, "R10 reset state", {50'd0, done, valid, code}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run(64'h0, 1, 0, "R1 zero wide");
        run(64'h0, 0, 0, "R1 zero narrow");
        run(64'h0000_0001_0000_0000, 0, 0, "R2 narrow upper bit");
        run(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R4 all ones");
        run(64'h0000_0000_FFFF_FFFF, 0, 0, "R4 narrow all ones");
        run(64'h0000_0000_0000_0005, 1, 0, "R4 two runs");
        run(64'h0000_0000_0000_0001, 1, 0, "R5 N bit");
        run(64'h8000_0000_0000_0000, 1, 0, "R6 top bit");
        run(64'hAAAA_AAAA_AAAA_AAAA, 1, 0, "R6 pair rotated");
        run(64'h5555_5555_5555_5555, 1, 0, "R7 pair prefix");
        run(64'h7777_7777_7777_7777, 1, 0, "R7 nibble prefix");
        run(64'h0F0F_0F0F_0F0F_0F0F, 1, 0, "R7 byte prefix");
        run(64'h00FF_00FF_00FF_00FF, 1, 0, "R3 halfword size");
        run(64'h0000_0000_F000_000F, 0, 0, "R6 narrow wrap");
        run(64'h0000_0FFF_0000_0FFF, 1, 0, "R3 word size in wide");
        run(64'h00FF_00FF_00FF_00FF, 1, 1, "R9 busy start");
        run(64'h0, 1, 1, "R9 busy start reject");

        for (int t = 0; t < 300; t++) begin
            int          lg, e, ones, rot;
            logic [63:0] elem, v;
            bit          wd;
            wd   = $urandom_range(0, 1);
            lg   = $urandom_range(1, wd ? 6 : 5);
            e    = 1 << lg;
            ones = $urandom_range(1, e - 1);
            rot  = $urandom_range(0, e - 1);
            elem = (64'd1 << ones) - 1;
            elem = ((elem << rot) | (elem >> (e - rot))) & ((e == 64) ? '1 : ((64'd1 << e) - 1));
            v = '0;
            for (int p = 0; p < (wd ? 64 : 32); p += e) v = v | (elem << p);
            if (t % 4 == 3) v = v ^ (64'd1 << $urandom_range(0, wd ? 63 : 31));
            if (t % 9 == 8) v = {$urandom, $urandom};
            run(v, wd, (t % 7 == 0), "R3 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule